// File: doc/BRIEF.md
# Debounced Battery Low Monitor

This block compares a sampled battery voltage, given as a millivolt code with a valid strobe, against a low threshold chosen by a select code. It gives two results. The first is an early-warning interrupt flag, which is latched and can be masked. The second is a power-off request. That request is raised only after the voltage has stayed under the threshold for a set number of 1 ms ticks, and it is released only with hysteresis. The power-mode controller uses the request to shut the supply down. The interrupt tells software early enough to close down in an orderly way.

The power-off path is a three-state machine:
- `ST_ARMED`: the voltage is normal.
- `ST_DEBOUNCE`: a low reading has been seen and ticks are being counted.
- `ST_TRIPPED`: the request is asserted.

The transitions are:
- *go_low* (ARMED→DEBOUNCE): a valid sample below the trip level.
- *recover* (DEBOUNCE→ARMED): a valid sample at or above the trip level.
- *expire* (DEBOUNCE→TRIPPED): the tick that completes the count.
- *release* (TRIPPED→ARMED): a valid sample at or above the trip level plus 50 mV.
- *disable* (any→ARMED): `en` is low.

The warning uses a separate one-bit latch.

Top module: `batt_low_monitor`

## Requirements
- R1: The trip level is 2500 + 50·`thr_sel` mV for `thr_sel` 0..20. A valid sample strictly below the trip level starts the debounce. A sample equal to the trip level does not start it.
- R2: Any `thr_sel` above 20 gives a trip level of 3500 mV.
- R3: `pwr_off_req` goes high after the clock edge that samples the 5th `tick_ms` pulse counted in `ST_DEBOUNCE`. Ticks counted are those after the sample that started the window. The request stays low after 4 such ticks.
- R4: A valid sample at or above the trip level during the debounce returns the machine to `ST_ARMED` and zeroes the count. After that, a new low sample and 5 more ticks are needed.
- R5: Once `pwr_off_req` is high, it stays high until a valid sample at or above the trip level + 50 mV. It drops after that sample's edge. Samples from the trip level up to trip + 49 mV keep it high.
- R6: `warn_irq` goes high after the edge where a valid sample lies below the trip level + 200 mV and `warn_mask` is 0. While `warn_mask` is 1, the flag is never set.
- R7: `warn_irq` stays high until a cycle with `warn_clr` = 1. A set and a clear in the same cycle leave it high. Raising `warn_mask` does not clear a flag that is already set.
- R8: After reset, and one edge after any cycle with `en` = 0, both outputs are 0 and the debounce count is zero. Samples and ticks seen while `en` is 0 have no effect.
- R9: When `smp_valid` is 0, the value on `smp_mv` has no effect on either output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Monitor enable |
| smp_valid | input | 1 | Strobe qualifying `smp_mv` |
| smp_mv | input | 13 | Battery voltage in millivolts |
| thr_sel | input | 5 | Threshold select code |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| warn_mask | input | 1 | 1 blocks the warning from being set |
| warn_clr | input | 1 | Clear strobe for the warning flag |
| warn_irq | output | 1 | Latched early-warning interrupt |
| pwr_off_req | output | 1 | Debounced power-off request |

## Verification
A wrong tick count in `ST_DEBOUNCE` shows up as `pwr_off_req` rising one tick too early or too late. A test that tries 4 and 5 ticks exposes it within 5 ms of the low sample. A missed restart, or a lost hysteresis margin, shows up one edge after the sample concerned, as a request that is high or low when it should not be. A warning latch stuck at the wrong value is seen at `warn_irq` one edge after the set or clear stimulus. Seeded random traffic concentrated around the three levels finds transitions that the directed cases do not cover.

// File: rtl/batt_low_pkg.sv
package batt_low_pkg;
    localparam int VOLT_W    = 13;
    localparam int SEL_W     = 5;
    localparam int BASE_MV   = 2500;
    localparam int STEP_MV   = 50;
    localparam int MAX_CODE  = 20;
    localparam int HYST_MV   = 50;
    localparam int WARN_MV   = 200;
    localparam int DEB_TICKS = 5;

    typedef enum logic [1:0] {
        ST_ARMED    = 2'd0,
        ST_DEBOUNCE = 2'd1,
        ST_TRIPPED  = 2'd2
    } mon_state_e;
endpackage

// File: rtl/batt_thr_calc.sv
module batt_thr_calc
    import batt_low_pkg::*;
#(
    parameter int VW    = VOLT_W,
    parameter int SW    = SEL_W,
    parameter int BASE  = BASE_MV,
    parameter int STEP  = STEP_MV,
    parameter int MAXC  = MAX_CODE,
    parameter int HYST  = HYST_MV,
    parameter int WARN  = WARN_MV
) (
    input  logic [SW-1:0] thr_sel,
    output logic [VW-1:0] trip_mv,
    output logic [VW-1:0] rel_mv,
    output logic [VW-1:0] warn_mv
);
    localparam logic [SW-1:0] MAX_SEL = SW'(MAXC);

    logic [SW-1:0] sel_c;

    always_comb begin
        sel_c   = (thr_sel > MAX_SEL) ? MAX_SEL : thr_sel;
        trip_mv = VW'(BASE) + VW'(STEP) * VW'(sel_c);
        rel_mv  = trip_mv + VW'(HYST);
        warn_mv = trip_mv + VW'(WARN);
    end

    always_comb begin
        AST_TRIP_RANGE: assert (trip_mv >= VW'(BASE) && trip_mv <= VW'(BASE + STEP * MAXC)); // R2
    end
endmodule

// File: rtl/batt_debounce_fsm.sv
module batt_debounce_fsm
    import batt_low_pkg::*;
#(
    parameter int VW    = VOLT_W,
    parameter int TICKS = DEB_TICKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          smp_valid,
    input  logic [VW-1:0] smp_mv,
    input  logic [VW-1:0] trip_mv,
    input  logic [VW-1:0] rel_mv,
    input  logic          tick_ms,
    output logic          pwr_off_req
);
    localparam int CNT_W = $clog2(TICKS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICKS - 1);

    mon_state_e     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic           is_low, is_clear;

    assign is_low   = smp_valid && (smp_mv < trip_mv);
    assign is_clear = smp_valid && (smp_mv >= rel_mv);

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!en) begin
            state_d = ST_ARMED;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_ARMED: begin
                    if (is_low) begin
                        state_d = ST_DEBOUNCE;
                        cnt_d   = '0;
                    end
                end
                ST_DEBOUNCE: begin
                    if (smp_valid && !is_low) begin
                        state_d = ST_ARMED;
                        cnt_d   = '0;
                    end else if (tick_ms) begin
                        if (cnt_q == LAST) begin
                            state_d = ST_TRIPPED;
                            cnt_d   = '0;
                        end else begin
                            cnt_d = cnt_q + 1'b1;
                        end
                    end
                end
                ST_TRIPPED: begin
                    if (is_clear) state_d = ST_ARMED;
                end
                default: begin
                    state_d = ST_ARMED;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ARMED;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        pwr_off_req = (state_q == ST_TRIPPED);
    end

    AST_TRIP_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwr_off_req) |-> $past(tick_ms) && $past(en)); // R3
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CNT_W'(TICKS)); // R3
    AST_RELEASE_HYST: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(pwr_off_req) && $past(en)) |-> ($past(smp_valid) && $past(smp_mv) >= $past(rel_mv))); // R5
    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!pwr_off_req && cnt_q == '0)); // R8
endmodule

// File: rtl/batt_warn_latch.sv
module batt_warn_latch
    import batt_low_pkg::*;
#(
    parameter int VW = VOLT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          smp_valid,
    input  logic [VW-1:0] smp_mv,
    input  logic [VW-1:0] warn_mv,
    input  logic          warn_mask,
    input  logic          warn_clr,
    output logic          warn_irq
);
    logic set_evt;

    assign set_evt = smp_valid && !warn_mask && (smp_mv < warn_mv);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        warn_irq <= 1'b0;
        else if (!en)      warn_irq <= 1'b0;
        else if (set_evt)  warn_irq <= 1'b1;
        else if (warn_clr) warn_irq <= 1'b0;
    end

    AST_WARN_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(warn_irq) |-> ($past(smp_valid) && !$past(warn_mask))); // R6
    AST_WARN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_irq && en && !warn_clr) |=> warn_irq); // R7
    AST_WARN_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !warn_irq); // R8
endmodule

// File: rtl/batt_low_monitor.sv
module batt_low_monitor
    import batt_low_pkg::*;
#(
    parameter int VW    = VOLT_W,
    parameter int SW    = SEL_W,
    parameter int TICKS = DEB_TICKS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          smp_valid,
    input  logic [VW-1:0] smp_mv,
    input  logic [SW-1:0] thr_sel,
    input  logic          tick_ms,
    input  logic          warn_mask,
    input  logic          warn_clr,
    output logic          warn_irq,
    output logic          pwr_off_req
);
    logic [VW-1:0] trip_mv, rel_mv, warn_mv;

    batt_thr_calc #(.VW(VW), .SW(SW)) u_thr (
        .thr_sel (thr_sel),
        .trip_mv (trip_mv),
        .rel_mv  (rel_mv),
        .warn_mv (warn_mv)
    );

    batt_debounce_fsm #(.VW(VW), .TICKS(TICKS)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .smp_valid   (smp_valid),
        .smp_mv      (smp_mv),
        .trip_mv     (trip_mv),
        .rel_mv      (rel_mv),
        .tick_ms     (tick_ms),
        .pwr_off_req (pwr_off_req)
    );

    batt_warn_latch #(.VW(VW)) u_warn (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .smp_valid (smp_valid),
        .smp_mv    (smp_mv),
        .warn_mv   (warn_mv),
        .warn_mask (warn_mask),
        .warn_clr  (warn_clr),
        .warn_irq  (warn_irq)
    );
endmodule

// File: tb/batt_low_monitor_tb.sv
module batt_low_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        smp_valid = 1'b0;
    logic [12:0] smp_mv = '0;
    logic [4:0]  thr_sel = '0;
    logic        tick_ms = 1'b0;
    logic        warn_mask = 1'b0;
    logic        warn_clr = 1'b0;
    logic        warn_irq;
    logic        pwr_off_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int m_st  = 0;
    int m_cnt = 0;
    bit m_warn = 0;

    always #10 clk = ~clk;

    batt_low_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .smp_valid(smp_valid), .smp_mv(smp_mv),
        .thr_sel(thr_sel), .tick_ms(tick_ms), .warn_mask(warn_mask), .warn_clr(warn_clr),
        .warn_irq(warn_irq), .pwr_off_req(pwr_off_req)
    );

    function automatic int trip_of(input int sel);
        return 2500 + 50 * ((sel > 20) ? 20 : sel);
    endfunction

    task automatic check(input string req, input bit act_p, input bit act_w);
        bit exp_p;
        exp_p = (m_st == 2);
        checks++;
        if (act_p !== exp_p || act_w !== m_warn) begin
            fails++;
            $display("FAIL %s: pwr_off_req=%0b warn_irq=%0b expected %0b %0b",
                     req, act_p, act_w, exp_p, m_warn);
        end
    endtask

    // one cycle: drive at negedge, update model, check at next negedge
    task automatic step(input bit e, input bit v, input int mv, input int sel,
                        input bit t, input bit mk, input bit c, input string req);
        int tr;
        en = e; smp_valid = v; smp_mv = 13'(mv); thr_sel = 5'(sel);
        tick_ms = t; warn_mask = mk; warn_clr = c;
        tr = trip_of(sel);
        if (!e) begin
            m_st = 0; m_cnt = 0; m_warn = 0;
        end else begin
            if (v && mv < tr + 200 && !mk) m_warn = 1;
            else if (c) m_warn = 0;
            case (m_st)
                0: if (v && mv < tr) begin m_st = 1; m_cnt = 0; end
                1: if (v && mv >= tr) begin m_st = 0; m_cnt = 0; end
                   else if (t) begin
                       if (m_cnt == 4) begin m_st = 2; m_cnt = 0; end
                       else m_cnt++;
                   end
                default: if (v && mv >= tr + 50) m_st = 0;
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        check(req, pwr_off_req, warn_irq);
    endtask

    task automatic ticks(input int n, input int sel, input string req);
        for (int i = 0; i < n; i++) begin
            step(1, 0, 0, sel, 1, 1, 0, req);
            step(1, 0, 0, sel, 0, 1, 0, req);
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        check("R8 reset", pwr_off_req, warn_irq);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8 after reset", pwr_off_req, warn_irq);

        // R1: equal to trip level does not start debounce (sel 10 -> 3000)
        step(1, 1, 3000, 10, 0, 1, 0, "R1 equal");
        ticks(6, 10, "R1 equal no trip");
        // R3: 4 ticks low, 5th trips
        step(1, 1, 2999, 10, 0, 1, 0, "R1 below");
        ticks(4, 10, "R3 four ticks");
        ticks(1, 10, "R3 fifth tick");
        // R5: hysteresis
        step(1, 1, 3049, 10, 0, 1, 0, "R5 inside hyst");
        step(1, 1, 3000, 10, 0, 1, 0, "R5 at trip");
        step(1, 1, 3050, 10, 0, 1, 0, "R5 release");
        // R4: restart
        step(1, 1, 2990, 10, 0, 1, 0, "R4 low");
        ticks(3, 10, "R4 partial");
        step(1, 1, 3000, 10, 0, 1, 0, "R4 restart");
        ticks(3, 10, "R4 armed ticks");
        step(1, 1, 2990, 10, 0, 1, 0, "R4 low again");
        ticks(4, 10, "R4 four fresh");
        ticks(1, 10, "R4 fifth fresh");
        step(1, 1, 3100, 10, 0, 1, 0, "R5 release2");
        // R2: clamp
        step(1, 1, 3499, 25, 0, 1, 0, "R2 clamp low");
        ticks(5, 25, "R2 clamp trip");
        step(1, 1, 3549, 31, 0, 1, 0, "R2 clamp hold");
        step(1, 1, 3550, 31, 0, 1, 0, "R2 clamp release");
        // R6/R7: warning
        step(1, 1, 3100, 10, 0, 1, 0, "R6 masked");
        step(1, 1, 3200, 10, 0, 0, 0, "R6 at warn level");
        step(1, 1, 3199, 10, 0, 0, 0, "R6 set");
        step(1, 1, 3500, 10, 0, 1, 0, "R7 hold under mask");
        step(1, 0, 0, 10, 0, 1, 1, "R7 clear");
        step(1, 1, 3150, 10, 0, 0, 1, "R7 set beats clear");
        step(1, 0, 0, 10, 0, 0, 0, "R7 held");
        // R9: invalid samples ignored
        step(1, 0, 100, 10, 0, 0, 1, "R9 clear");
        for (int i = 0; i < 6; i++) step(1, 0, 100, 10, 1, 0, 0, "R9 invalid low");
        // R8: disable
        step(1, 1, 2000, 10, 0, 0, 0, "R8 low");
        ticks(5, 10, "R8 trip");
        step(0, 0, 0, 10, 0, 0, 0, "R8 disable");
        for (int i = 0; i < 6; i++) step(0, 1, 2000, 10, 1, 0, 0, "R8 ignored");
        step(1, 0, 0, 10, 1, 0, 0, "R8 reenable");

        // random traffic around the levels
        for (int i = 0; i < 4000; i++) begin
            int sel, mv;
            sel = int'($urandom_range(0, 23));
            mv  = trip_of(sel) + int'($urandom_range(0, 300)) - 60;
            step(($urandom_range(0, 99) != 0), ($urandom_range(0, 3) == 0), mv,
                 (i % 500 < 250) ? 10 : sel, ($urandom_range(0, 4) == 0),
                 ($urandom_range(0, 3) == 0), ($urandom_range(0, 9) == 0),
                 "R3/R4/R5/R6 random");
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule